// File: doc/BRIEF.md
# UART Receive Status and Interrupt Flag Register

This block is the status side of one UART channel. The receiver stores each incoming byte in a receive queue. Each entry also carries four condition tags: line break, framing error, parity error and overrun. A CPU read of the receive data port pops the oldest entry. A 32-bit status word shows the tags of the entry now at the head of the queue, together with an empty indication whose sense is inverted (1 means nothing to read).

The same word holds four sticky event flags: receive error, receive timeout, transmit space available and receive level reached. An event sets its flag. Software clears a flag by writing 0 to its bit; writing 1 leaves it unchanged. The interrupt output is the OR of the four flags. The serial shifter, the baud generator and the timeout counter are outside the block. The timeout counter arrives as a one-cycle pulse, and the transmit queue reports its free space as a count.

Top module: `uart_rx_status`

## Requirements
- R1: Status bits 15 (break), 13 (framing), 12 (parity) and 11 (overrun) show the tags of the head entry of the receive queue. All four read 0 while the queue is empty.
- R2: A pop when the queue holds data advances to the next entry. The head tags and the data change after that clock edge. A pop on an empty queue has no effect.
- R3: Status bit 14 reads 1 when the receive queue is empty and 0 otherwise. It is 1 after reset.
- R4: Bit 10 becomes 1 at the clock edge where a byte with a framing, parity or overrun tag is pushed, or where a push is dropped.
- R5: Bit 9 becomes 1 at the clock edge where the timeout pulse input is high.
- R6: Bit 8 becomes 1 at any clock edge where the transmit free count is at least the transmit trigger level. It is 1 after reset.
- R7: Bit 7 becomes 1 at any clock edge where the receive queue occupancy before that edge is at least the receive trigger level. It is 0 after reset.
- R8: Writing the status word with a 0 in bit 7, 8, 9 or 10 clears that flag. Writing a 1 leaves the flag as it was. When the flag's set condition holds in the same cycle as the clear, the flag is 1.
- R9: The receive queue holds DEPTH (16) entries. A push into a full queue without a pop in the same cycle is dropped, and the newest stored entry gets its overrun tag set.
- R10: Status bits 31 to 16 and 6 to 0 read 0.
- R11: The interrupt output is 1 exactly when at least one of bits 10 to 7 is 1.
- R12: The data output shows the byte of the head entry, and 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Receiver stores a byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_brk | input | 1 | Break tag of the pushed byte |
| rx_ferr | input | 1 | Framing error tag of the pushed byte |
| rx_perr | input | 1 | Parity error tag of the pushed byte |
| rx_ovr | input | 1 | Overrun tag of the pushed byte |
| rx_pop | input | 1 | CPU read of the receive data port |
| rx_tmo | input | 1 | One-cycle receive timeout pulse |
| tx_space | input | 5 | Free entries in the transmit queue |
| rx_level | input | 4 | Receive trigger level |
| tx_level | input | 4 | Transmit trigger level |
| csr_we | input | 1 | Write strobe for the status word |
| csr_wdata | input | 32 | Write data for the status word |
| rx_data | output | 8 | Byte at the head of the receive queue |
| csr_stat | output | 32 | Status word |
| irq | output | 1 | OR of the four sticky flags |

## Verification
The bench fills the queue past its depth. A design that overwrote an entry, or moved the count past 16, or put the overrun tag on the wrong entry, would show wrong head tags as the queue drains. It pops an empty queue, where a broken pointer would make later bytes appear out of order. It also pairs a write of 0 with a set event on the same flag: a design that let the clear win would lose an interrupt. It writes ones over flags that are clear, which must not set them. Trigger levels of 0 and 15 test both ends of the comparisons, where an off-by-one gives a flag one cycle or one entry too early or too late.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  // status word bit positions, read by software
  localparam int unsigned SB_BRK   = 15;
  localparam int unsigned SB_EMPTY = 14;
  localparam int unsigned SB_FERR  = 13;
  localparam int unsigned SB_PERR  = 12;
  localparam int unsigned SB_OVR   = 11;
  localparam int unsigned SB_FLAG0 = 7;   // flags occupy 7..10
  localparam int unsigned NFLAGS   = 4;   // 0 level,1 tx space,2 timeout,3 error

endpackage

// File: rtl/uart_tag_fifo.sv
module uart_tag_fifo
  import uart_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  rx_entry_t        entry_i,
  input  logic             ovr_i,
  input  logic             pop_i,
  output rx_entry_t        head_o,
  output logic             head_ovr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             drop_o
);

  rx_entry_t        mem [DEPTH];
  logic [DEPTH-1:0] ovr_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [CNT_W-1:0] count_q;
  logic             full, empty, do_pop, do_push;

  assign full     = (count_q == CNT_W'(DEPTH));
  assign empty    = (count_q == '0);
  assign do_pop   = pop_i && !empty;
  assign do_push  = push_i && (!full || do_pop);
  assign drop_o   = push_i && full && !pop_i;
  assign last_ptr = wr_ptr - PTR_W'(1);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= entry_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) begin
        ovr_q[wr_ptr] <= ovr_i;
        wr_ptr        <= wr_ptr + PTR_W'(1);
      end
      if (drop_o) ovr_q[last_ptr] <= 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
      count_q <= count_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assign head_o     = mem[rd_ptr];
  assign head_ovr_o = ovr_q[rd_ptr];
  assign count_o    = count_q;

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  a_r9_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
    drop_o |=> $stable(count_q));

  a_r2_pop_advances: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !empty && !push_i) |=> (count_q == $past(count_q) - CNT_W'(1)));

  a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty && !push_i) |=> $stable(rd_ptr) && (count_q == '0));

endmodule

// File: rtl/uart_sticky_bit.sv
module uart_sticky_bit #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdat_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)                flag_q <= RESET_VAL;
    else if (set_i)         flag_q <= 1'b1;
    else if (wr_i && !wdat_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);

  a_r8_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !wdat_i && !set_i) |=> !flag_q);

  a_r8_one_holds: assert property (@(posedge clk) disable iff (rst)
    (!set_i && (!wr_i || wdat_i)) |=> $stable(flag_q));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_stat_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned TRIG_W = 4,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              rx_brk,
  input  logic              rx_ferr,
  input  logic              rx_perr,
  input  logic              rx_ovr,
  input  logic              rx_pop,
  input  logic              rx_tmo,
  input  logic [CNT_W-1:0]  tx_space,
  input  logic [TRIG_W-1:0] rx_level,
  input  logic [TRIG_W-1:0] tx_level,
  input  logic              csr_we,
  input  logic [31:0]       csr_wdata,
  output logic [7:0]        rx_data,
  output logic [31:0]       csr_stat,
  output logic              irq
);

  localparam logic [NFLAGS-1:0] FLAG_RST = 4'b0010; // tx space flag starts set

  rx_entry_t         in_ent, head;
  logic              head_ovr, drop;
  logic [CNT_W-1:0]  count;
  logic              is_empty;
  logic [NFLAGS-1:0] set_vec, flags;

  assign in_ent = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_byte};

  uart_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_i    (rx_push),
    .entry_i   (in_ent),
    .ovr_i     (rx_ovr),
    .pop_i     (rx_pop),
    .head_o    (head),
    .head_ovr_o(head_ovr),
    .count_o   (count),
    .drop_o    (drop)
  );

  assign is_empty = (count == '0);

  assign set_vec[0] = (count >= CNT_W'(rx_level));
  assign set_vec[1] = (tx_space >= CNT_W'(tx_level));
  assign set_vec[2] = rx_tmo;
  assign set_vec[3] = (rx_push && (rx_ferr || rx_perr || rx_ovr)) || drop;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    uart_sticky_bit #(.RESET_VAL(FLAG_RST[g])) u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_vec[g]),
      .wr_i  (csr_we),
      .wdat_i(csr_wdata[SB_FLAG0 + g]),
      .flag_o(flags[g])
    );
  end

  always_comb begin
    csr_stat                              = '0;
    csr_stat[SB_BRK]                      = !is_empty && head.brk;
    csr_stat[SB_EMPTY]                    = is_empty;
    csr_stat[SB_FERR]                     = !is_empty && head.ferr;
    csr_stat[SB_PERR]                     = !is_empty && head.perr;
    csr_stat[SB_OVR]                      = !is_empty && head_ovr;
    csr_stat[SB_FLAG0 +: NFLAGS]          = flags;
  end

  assign rx_data = is_empty ? 8'h00 : head.data;
  assign irq     = |flags;

  a_r3_drain_shows_empty: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_push && count == CNT_W'(1)) |=> csr_stat[SB_EMPTY]);

  a_r3_push_clears_empty: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !csr_stat[SB_EMPTY]);

  a_r6_tx_space_sets: assert property (@(posedge clk) disable iff (rst)
    (tx_space >= CNT_W'(tx_level)) |=> csr_stat[8]);

  a_r4_error_push_sets: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_ferr) |=> irq);

endmodule

// File: tb/tb_uart_rx_status.sv
`timescale 1ns/1ps
module tb_uart_rx_status;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_push = 0, rx_brk = 0, rx_ferr = 0, rx_perr = 0, rx_ovr = 0;
  logic        rx_pop = 0, rx_tmo = 0, csr_we = 0;
  logic [7:0]  rx_byte = 0;
  logic [4:0]  tx_space = 0;
  logic [3:0]  rx_level = 0, tx_level = 0;
  logic [31:0] csr_wdata = 0;
  logic [7:0]  rx_data;
  logic [31:0] csr_stat;
  logic        irq;

  always #2.5 clk = ~clk;

  uart_rx_status dut (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr),
    .rx_pop(rx_pop), .rx_tmo(rx_tmo), .tx_space(tx_space),
    .rx_level(rx_level), .tx_level(tx_level), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .rx_data(rx_data), .csr_stat(csr_stat), .irq(irq)
  );

  int unsigned nchk = 0, nfail = 0;
  bit          done = 0;

  // model: entry = {brk, ferr, perr, ovr, data}
  logic [11:0] q[$];
  logic [3:0]  mflag = 4'b0010;   // 0 level, 1 tx space, 2 timeout, 3 error

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare();
    logic [11:0] h;
    logic        e;
    e = (q.size() == 0);
    h = e ? 12'h0 : q[0];
    chk("R1 head tags", {28'h0, csr_stat[15], csr_stat[13:11]}, {28'h0, h[11:8]});
    chk("R3 empty bit", {31'h0, csr_stat[14]}, {31'h0, e});
    chk("R4 R5 R6 R7 R8 flags", {28'h0, csr_stat[10:7]}, {28'h0, mflag});
    chk("R10 reserved", {csr_stat[31:16], 9'h0, csr_stat[6:0]}, 32'h0);
    chk("R11 irq", {31'h0, irq}, {31'h0, |mflag});
    chk("R12 data", {24'h0, rx_data}, {24'h0, h[7:0]});
  endtask

  // apply current inputs for one clock, advance model, compare
  task automatic step();
    logic [3:0] setv;
    logic       drop, popok;
    int         sz;
    sz    = q.size();
    popok = rx_pop && sz > 0;
    drop  = rx_push && sz == 16 && !rx_pop;
    setv[0] = (sz >= int'(rx_level));
    setv[1] = (tx_space >= {1'b0, tx_level});
    setv[2] = rx_tmo;
    setv[3] = (rx_push && (rx_ferr || rx_perr || rx_ovr)) || drop;
    for (int i = 0; i < 4; i++) begin
      if (setv[i]) mflag[i] = 1'b1;
      else if (csr_we && !csr_wdata[7+i]) mflag[i] = 1'b0;
    end
    if (drop) q[15][8] = 1'b1;       // R9 newest entry tagged overrun
    else begin
      if (popok) void'(q.pop_front());  // R2
      if (rx_push) q.push_back({rx_brk, rx_ferr, rx_perr, rx_ovr, rx_byte});
    end
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic idle();
    rx_push = 0; rx_pop = 0; rx_tmo = 0; csr_we = 0;
    rx_brk = 0; rx_ferr = 0; rx_perr = 0; rx_ovr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    tx_level = 4'd5; tx_space = 5'd0; rx_level = 4'd15;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #0;
    // R3 R6 R7 reset state
    chk("R3 reset stat", csr_stat, 32'h0000_4100);
    chk("R11 reset irq", {31'h0, irq}, 32'h1);

    // R8 write zero clears tx flag while its condition is false
    idle(); csr_we = 1; csr_wdata = 32'h0; step();
    // R8 writing ones sets nothing
    csr_wdata = 32'hFFFF_FFFF; step();
    idle();

    // R9 fill past depth, with errors on some bytes
    for (int i = 0; i < 18; i++) begin
      rx_push = 1; rx_byte = 8'(8'h30 + i);
      rx_brk = (i == 2); rx_perr = (i == 4); rx_ferr = 0; rx_ovr = 0;
      step();
    end
    idle();
    // R8 set wins against same-cycle clear
    rx_tmo = 1; csr_we = 1; csr_wdata = 32'h0; step();
    idle();
    // R2 drain and pop on empty
    for (int i = 0; i < 20; i++) begin rx_pop = 1; step(); end
    // R2 push and pop together on empty: push kept
    rx_push = 1; rx_byte = 8'hA5; step();
    idle(); rx_pop = 1; rx_push = 1; rx_byte = 8'h5A; step();
    // R6 R7 boundary levels
    idle(); rx_level = 4'd0; tx_level = 4'd0; tx_space = 5'd0; step();
    csr_we = 1; csr_wdata = 32'h0; rx_level = 4'd2; tx_level = 4'd15; tx_space = 5'd14; step();
    idle(); tx_space = 5'd15; step();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned phase;
      phase = (n / 400) % 3;
      rx_push = ($urandom % 4) < (phase == 0 ? 3 : phase == 1 ? 1 : 2);
      rx_pop  = ($urandom % 4) < (phase == 0 ? 1 : phase == 1 ? 3 : 2);
      rx_byte = 8'($urandom);
      rx_brk  = ($urandom % 8) == 0;
      rx_ferr = ($urandom % 10) == 0;
      rx_perr = ($urandom % 10) == 0;
      rx_ovr  = ($urandom % 16) == 0;
      rx_tmo  = ($urandom % 30) == 0;
      csr_we  = ($urandom % 6) == 0;
      csr_wdata = $urandom;
      if (($urandom % 50) == 0) rx_level = 4'($urandom);
      if (($urandom % 50) == 0) tx_level = 4'($urandom);
      tx_space = 5'($urandom % 17);
      step();
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule